// File: doc/BRIEF.md
# CAN Transmit Dominant-Timeout Guard

This block sits between the synchronized transmit-data line from a CAN protocol controller and the bus driver stage. It passes a dominant request (transmit data low) to the driver and blocks it in three cases: the node is not in its active mode, transmit data has been held low for too long, or the die over-temperature flag has tripped. The block keeps the bus recessive in each of these cases. A controller whose transmit output is stuck low therefore cannot block the network.

The dominant window is a parameter in clock cycles. Its default of 25000 cycles at 50 MHz gives 500 µs, which lies inside the usual 300 to 1000 µs range. The shortest timeout sets the lowest usable bit rate, which is about 40 kbit/s. A timeout releases only on a rising edge of transmit data. A thermal trip releases only once the temperature flag has cleared and transmit data is high. A stuck-low line therefore never drives the bus again, whatever caused the shutdown. The timeout and the thermal disable are reported on two separate flags.

Top module: `can_tx_guard`

## Requirements
- R1: After reset, drv_dom, tmo_off and hot_off are all 0.
- R2: With act_en=1 and both flags clear, drv_dom equals the inverse of txd in the same cycle (txd=0 means dominant, drv_dom=1 means drive dominant).
- R3: While act_en=1 and txd=0 at every rising clock edge, tmo_off is set at the TIMEOUT_CYC-th such edge. drv_dom stays 1 before that edge and is 0 from that edge on.
- R4: tmo_off clears at the first clock edge where txd is 1 and txd was 0 at the previous edge. A later low on txd then drives dominant again at once.
- R5: The dominant counter saturates. Holding txd low for several times TIMEOUT_CYC keeps tmo_off=1 and drv_dom=0, with no wrap-around re-enable.
- R6: A single cycle with txd high restarts the count. Low stretches of TIMEOUT_CYC-1 edges separated by one high cycle never set tmo_off.
- R7: overtemp=1 at a clock edge sets hot_off at that edge. While hot_off=1, drv_dom=0 whatever txd is, and tmo_off is not affected.
- R8: hot_off clears only at an edge where overtemp=0 and txd=1. It stays set while txd is low, even after overtemp has dropped.
- R9: act_en=0 forces drv_dom=0 in the same cycle. At the next edge it clears the dominant counter and tmo_off, so a low txd after re-enable gets a full TIMEOUT_CYC window.
- R10: tmo_off and hot_off are independent. A thermal trip does not set tmo_off, and a timeout does not set hot_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Synchronized transmit data, 0 = dominant request |
| act_en | input | 1 | Active-mode enable from the mode controller |
| overtemp | input | 1 | Digital over-temperature flag |
| drv_dom | output | 1 | Driver command, 1 = drive bus dominant |
| tmo_off | output | 1 | Transmitter disabled by dominant timeout |
| hot_off | output | 1 | Transmitter disabled by thermal shutdown |

## Verification
The hardest cases to reach are the boundaries of the timeout window. One is the edge where the counter reaches its limit. The other is a low stretch one cycle shorter than that limit, followed by a single high cycle that must restart the count. The bench overrides TIMEOUT_CYC to a small value. It times txd transitions from clock edges and samples at the edges on either side of the limit. A second hard case is a thermal release attempted while txd is still low. The bench reaches it by dropping overtemp during a low stretch shorter than the timeout, then raising txd only later.

// File: rtl/cantg_pkg.sv
package cantg_pkg;
  // Combined disable status carried from the guard stages to the top.
  typedef struct packed {
    logic timeout;
    logic thermal;
  } cantg_stat_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/cantg_edge.sv
module cantg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  output logic rise
);
  logic txd_q;
  logic txd_d;

  always_comb txd_d = txd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_q <= 1'b1;
    else        txd_q <= txd_d;
  end

  assign rise = txd & ~txd_q;
endmodule

// File: rtl/cantg_dom_timer.sv
module cantg_dom_timer #(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_en,
  input  logic txd,
  input  logic rise,
  output logic tmo
);
  localparam int unsigned CW = cantg_pkg::cnt_bits(TIMEOUT_CYC);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!act_en || txd)   cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    tmo_d = tmo_q;
    if (!act_en)                        tmo_d = 1'b0;
    else if (rise)                      tmo_d = 1'b0;
    else if (!txd && (cnt_d == LIM))    tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo = tmo_q;
endmodule

// File: rtl/cantg_therm.sv
module cantg_therm (
  input  logic clk,
  input  logic rst_n,
  input  logic overtemp,
  input  logic txd,
  output logic hot
);
  logic hot_q, hot_d;

  always_comb begin
    hot_d = hot_q;
    if (overtemp)         hot_d = 1'b1;
    else if (txd)         hot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_d;
  end

  assign hot = hot_q;
endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  input  logic act_en,
  input  logic overtemp,
  output logic drv_dom,
  output logic tmo_off,
  output logic hot_off
);
  import cantg_pkg::*;

  logic        rise;
  cantg_stat_t stat;

  cantg_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .txd  (txd),
    .rise (rise)
  );

  cantg_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .act_en(act_en),
    .txd   (txd),
    .rise  (rise),
    .tmo   (stat.timeout)
  );

  cantg_therm u_therm (
    .clk     (clk),
    .rst_n   (rst_n),
    .overtemp(overtemp),
    .txd     (txd),
    .hot     (stat.thermal)
  );

  assign drv_dom = act_en & ~txd & ~stat.timeout & ~stat.thermal;
  assign tmo_off = stat.timeout;
  assign hot_off = stat.thermal;
endmodule

// File: rtl/cantg_checker.sv
module cantg_checker #(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic act_en,
  input logic overtemp,
  input logic drv_dom,
  input logic tmo_off,
  input logic hot_off
);
  localparam int unsigned CW = cantg_pkg::cnt_bits(TIMEOUT_CYC);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

  // Independent count of consecutive enabled low edges.
  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= '0;
    else if (!act_en || txd)   low_run <= '0;
    else if (low_run != LIM)   low_run <= low_run + 1'b1;
  end

  assert_dom_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom |-> (!txd && act_en));

  assert_window_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !txd && low_run == LIM - 1'b1) |=> tmo_off);

  assert_no_dom_past_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run == LIM) |-> !drv_dom);

  assert_tmo_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_off) |-> (!$past(act_en) || ($past(txd) && !$past(txd, 2))));

  assert_hot_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> (hot_off && !drv_dom));

  assert_hot_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_off) |-> ($past(txd) && !$past(overtemp)));

  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !tmo_off);
endmodule

bind can_tx_guard cantg_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .txd     (txd),
  .act_en  (act_en),
  .overtemp(overtemp),
  .drv_dom (drv_dom),
  .tmo_off (tmo_off),
  .hot_off (hot_off)
);

// File: tb/can_tx_guard_test.sv
module can_tx_guard_test;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n, txd, act_en, overtemp;
  logic drv_dom, tmo_off, hot_off;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_tx_guard #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .act_en(act_en), .overtemp(overtemp),
    .drv_dom(drv_dom), .tmo_off(tmo_off), .hot_off(hot_off)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; txd = 1'b1; act_en = 1'b1; overtemp = 1'b0;
    step(2);
    chk("R1", drv_dom, 1'b0, "drv_dom in reset");
    chk("R1", tmo_off, 1'b0, "tmo_off in reset");
    chk("R1", hot_off, 1'b0, "hot_off in reset");
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_pass;
    txd = 1'b0; #1;
    chk("R2", drv_dom, 1'b1, "low passes");
    step(3);
    txd = 1'b1; #1;
    chk("R2", drv_dom, 1'b0, "high recessive");
    step(2);
  endtask

  task automatic t_timeout;
    txd = 1'b0;
    step(T - 1);
    chk("R3", drv_dom, 1'b1, "dominant before limit");
    chk("R3", tmo_off, 1'b0, "no timeout before limit");
    step(1);
    chk("R3", drv_dom, 1'b0, "blocked at limit");
    chk("R3", tmo_off, 1'b1, "timeout at limit");
    chk("R10", hot_off, 1'b0, "timeout leaves hot_off");
    step(3 * T);
    chk("R5", tmo_off, 1'b1, "saturated timeout holds");
    chk("R5", drv_dom, 1'b0, "saturated still blocked");
    txd = 1'b1;
    step(1);
    chk("R4", tmo_off, 1'b0, "rise clears timeout");
    txd = 1'b0; #1;
    chk("R4", drv_dom, 1'b1, "dominant again after rise");
    txd = 1'b1;
    step(2);
  endtask

  task automatic t_short;
    txd = 1'b0;  step(T - 1);
    txd = 1'b1;  step(1);
    txd = 1'b0;  step(T - 1);
    chk("R6", tmo_off, 1'b0, "restart by one high cycle");
    chk("R6", drv_dom, 1'b1, "still dominant");
    txd = 1'b1;  step(2);
  endtask

  task automatic t_thermal;
    overtemp = 1'b1;
    step(1);
    chk("R7", hot_off, 1'b1, "overtemp sets hot_off");
    txd = 1'b0; #1;
    chk("R7", drv_dom, 1'b0, "hot blocks dominant");
    overtemp = 1'b0;
    step(3);
    chk("R8", hot_off, 1'b1, "txd low holds hot_off");
    chk("R10", tmo_off, 1'b0, "thermal leaves tmo_off");
    txd = 1'b1;
    step(1);
    chk("R8", hot_off, 1'b0, "release with txd high");
    txd = 1'b0; #1;
    chk("R8", drv_dom, 1'b1, "dominant after thermal release");
    txd = 1'b1;
    step(2);
  endtask

  task automatic t_standby;
    txd = 1'b0; act_en = 1'b0; #1;
    chk("R9", drv_dom, 1'b0, "standby forces recessive");
    act_en = 1'b1;
    step(T);
    chk("R9", tmo_off, 1'b1, "timeout before standby");
    act_en = 1'b0;
    step(1);
    chk("R9", tmo_off, 1'b0, "standby clears timeout");
    act_en = 1'b1;
    step(T - 1);
    chk("R9", drv_dom, 1'b1, "full window after re-enable");
    step(1);
    chk("R9", tmo_off, 1'b1, "timeout again after full window");
    txd = 1'b1;
    step(2);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_timeout();
    t_short();
    t_thermal();
    t_standby();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule